// File: doc/BRIEF.md
# Card Clock Phase Select Register

This block is a single 32-bit control register that sits in a card host controller and sets how the card clock is timed. It stores three 3-bit fields: the phase at which incoming card data is sampled, the phase shift applied to outgoing command and data lines, and the divider for the internal card clock. It also holds one sticky wake-up flag that hardware sets and software clears by writing a one to it.

Two controls come out of the stored fields. The first is a command word merge: whenever any drive phase shift is configured, the hold-register select bit of every outgoing command word is forced high; otherwise the command word passes through untouched. The second is a divided bus-clock enable: a single-cycle pulse once every divider+1 input clocks. The pulse period picks up a new divider value only when the current count period ends.

Software uses a plain write strobe with a 32-bit data word and reads the register back at all times. An external wake event input sets the flag, and an interrupt output follows it.

Top module: `cclk_phase_ctrl`

## Requirements
- R1: After reset every field reads zero, the wake flag is clear, the interrupt output is low and the readback word is all zeros.
- R2: A write stores bits 2:0 as the sample phase, bits 18:16 as the drive phase and bits 26:24 as the divider; readback returns each field at the same position.
- R3: All readback bits other than 2:0, 11, 18:16 and 26:24 are zero, and writes to them have no effect.
- R4: A one on the wake event input sets the wake flag (readback bit 11) at the next clock edge; the flag then stays set without further events, and the interrupt output is high exactly while the flag is set.
- R5: A write with bit 11 high clears the wake flag; a write with bit 11 low leaves it unchanged.
- R6: When a wake event and a clearing write arrive in the same cycle, the wake flag ends up set.
- R7: When the drive phase is nonzero, bit 29 of the outgoing command word is 1; when it is zero, bit 29 equals the incoming bit 29. All other command bits pass through unchanged.
- R8: With the divider set to D in steady state, the bus clock enable is high for one cycle every D+1 input clock cycles (every cycle when D is 0).
- R9: A divider change made mid-period does not shorten or stretch the period in progress or the one whose start coincides with the write edge; the new length applies from the following restart.
- R10: A read-modify-write that changes only the sample phase leaves the drive phase, divider and wake flag as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register readback |
| wake_evt | input | 1 | Wake event, sets the sticky flag |
| irq | output | 1 | Interrupt, high while the wake flag is set |
| cmd_in | input | 32 | Command word from the command path |
| cmd_out | output | 32 | Command word with hold select merged |
| bus_clk_en | output | 1 | Divided bus clock enable pulse |

## Verification
The bench sweeps all 512 field combinations with every reserved bit driven high, so a mis-placed slice or a leaky reserved bit shows up as a readback mismatch. It goes after the wake-flag races: a set and clear in the same cycle, which a clear-priority design would lose, and writes of zero to bit 11, which a plain-storage design would treat as a clear. Every divider value has its pulse spacing measured, and a divider change written on a pulse edge must keep the old period once more; a design that reloads immediately would give a short gap there. Every drive phase is crossed with both values of the incoming hold bit to catch a merge that uses only one bit of the drive field or clears the bit when it should pass it.

// File: rtl/cps_pkg.sv
package cps_pkg;
    localparam int REG_W    = 32;
    localparam int FLD_W    = 3;
    localparam int SMP_LSB  = 0;
    localparam int DRV_LSB  = 16;
    localparam int DIV_LSB  = 24;
    localparam int WAKE_BIT = 11;
    localparam int HOLD_BIT = 29;

    typedef struct packed {
        logic [FLD_W-1:0] smp;
        logic [FLD_W-1:0] drv;
        logic [FLD_W-1:0] div;
        logic             wake;
    } cps_fields_t;
endpackage

// File: rtl/cps_field_store.sv
module cps_field_store
    import cps_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wake_evt,
    output cps_fields_t   fld_o,
    output logic [DW-1:0] rd_data
);
    cps_fields_t fld_d, fld_q;

    always_comb begin
        fld_d = fld_q;
        if (wr_en) begin
            fld_d.smp = wr_data[SMP_LSB +: FLD_W];
            fld_d.drv = wr_data[DRV_LSB +: FLD_W];
            fld_d.div = wr_data[DIV_LSB +: FLD_W];
            if (wr_data[WAKE_BIT]) begin
                fld_d.wake = 1'b0;
            end
        end
        // a new event outranks a simultaneous clear
        if (wake_evt) begin
            fld_d.wake = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end

    always_comb begin
        rd_data                     = '0;
        rd_data[SMP_LSB +: FLD_W]   = fld_q.smp;
        rd_data[DRV_LSB +: FLD_W]   = fld_q.drv;
        rd_data[DIV_LSB +: FLD_W]   = fld_q.div;
        rd_data[WAKE_BIT]           = fld_q.wake;
    end

    assign fld_o = fld_q;
endmodule

// File: rtl/cps_clk_div.sv
module cps_clk_div #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] div_i,
    output logic          tick_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    wrap;

    assign wrap = (st_q.cnt == st_q.lim);

    always_comb begin
        st_d = st_q;
        if (wrap) begin
            st_d.cnt = '0;
            st_d.lim = div_i;   // new length is sampled only at restart
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = wrap;
endmodule

// File: rtl/cps_cmd_hold.sv
module cps_cmd_hold #(
    parameter int DW      = 32,
    parameter int CW      = 3,
    parameter int HOLD_IX = 29
) (
    input  logic [CW-1:0] drv_i,
    input  logic [DW-1:0] cmd_i,
    output logic [DW-1:0] cmd_o
);
    logic shifted;

    assign shifted = |drv_i;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (b == HOLD_IX) begin : g_hold
            assign cmd_o[b] = cmd_i[b] | shifted;
        end else begin : g_pass
            assign cmd_o[b] = cmd_i[b];
        end
    end
endmodule

// File: rtl/cclk_phase_ctrl.sv
module cclk_phase_ctrl
    import cps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             wake_evt,
    output logic             irq,
    input  logic [REG_W-1:0] cmd_in,
    output logic [REG_W-1:0] cmd_out,
    output logic             bus_clk_en
);
    cps_fields_t fld;

    cps_field_store #(.DW(REG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wake_evt (wake_evt),
        .fld_o    (fld),
        .rd_data  (rd_data)
    );

    cps_clk_div #(.CW(FLD_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (fld.div),
        .tick_o (bus_clk_en)
    );

    cps_cmd_hold #(.DW(REG_W), .CW(FLD_W), .HOLD_IX(HOLD_BIT)) u_hold (
        .drv_i (fld.drv),
        .cmd_i (cmd_in),
        .cmd_o (cmd_out)
    );

    assign irq = fld.wake;
endmodule

// File: rtl/cps_checker.sv
module cps_checker
    import cps_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             wake_evt,
    input logic             irq,
    input logic [REG_W-1:0] cmd_in,
    input logic [REG_W-1:0] cmd_out
);
    localparam logic [REG_W-1:0] LIVE_MASK =
        (REG_W'((1 << FLD_W) - 1) << SMP_LSB) |
        (REG_W'((1 << FLD_W) - 1) << DRV_LSB) |
        (REG_W'((1 << FLD_W) - 1) << DIV_LSB) |
        (REG_W'(1) << WAKE_BIT);
    localparam logic [REG_W-1:0] HOLD_MASK = REG_W'(1) << HOLD_BIT;

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~LIVE_MASK) == '0);

    a_r4_wake_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> irq);

    a_r4_irq_tracks_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq == rd_data[WAKE_BIT]);

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && wr_data[WAKE_BIT])) |=> irq);

    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[WAKE_BIT] && !wake_evt) |=> !irq);

    a_r7_hold_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[DRV_LSB +: FLD_W] != '0) |-> cmd_out[HOLD_BIT]);

    a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_out ^ cmd_in) & ~HOLD_MASK) == '0);

    a_r7_hold_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[DRV_LSB +: FLD_W] == '0) |-> (cmd_out[HOLD_BIT] == cmd_in[HOLD_BIT]));
endmodule

bind cclk_phase_ctrl cps_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .wake_evt (wake_evt),
    .irq      (irq),
    .cmd_in   (cmd_in),
    .cmd_out  (cmd_out)
);

// File: tb/tb_cclk_phase_ctrl.sv
module tb_cclk_phase_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        wake_evt = 1'b0;
    logic        irq;
    logic [31:0] cmd_in = '0;
    logic [31:0] cmd_out;
    logic        bus_clk_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cclk_phase_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wake_evt(wake_evt), .irq(irq),
        .cmd_in(cmd_in), .cmd_out(cmd_out), .bus_clk_en(bus_clk_en)
    );

    function automatic logic [31:0] pack(int s, int d, int v);
        return (32'(s) & 7) | ((32'(d) & 7) << 16) | ((32'(v) & 7) << 24);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [31:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic sync_tick();
        while (!bus_clk_en) @(negedge clk);
    endtask

    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bus_clk_en);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] fill, v;
        int n;
        fill = ~(pack(7, 7, 7) | 32'h0000_0800);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 readback", rd_data, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 / R3 full field sweep with reserved bits driven high
        for (int s = 0; s < 8; s++)
            for (int d = 0; d < 8; d++)
                for (int q = 0; q < 8; q++) begin
                    reg_wr(fill | pack(s, d, q));
                    chk("R2 fields", rd_data & pack(7, 7, 7), pack(s, d, q));
                    chk("R3 reserved", rd_data & fill, 32'h0);
                end

        // R7 hold merge for every drive phase and both incoming bit values
        for (int d = 0; d < 8; d++)
            for (int b = 0; b < 2; b++) begin
                reg_wr(pack(1, d, 0));
                cmd_in = 32'h0A5A_0F0F | (32'(b) << 29);
                #1;
                chk("R7 cmd merge", cmd_out,
                    32'h0A5A_0F0F | (32'(b) << 29) | ((d != 0) ? 32'h2000_0000 : 32'h0));
            end
        cmd_in = 32'hDFFF_FFFF;
        reg_wr(pack(0, 0, 0));
        #1;
        chk("R7 zero drive pass", cmd_out, 32'hDFFF_FFFF);

        // R10 read-modify-write of the sample field
        reg_wr(pack(2, 5, 3));
        v = (rd_data & ~32'h7) | 32'h6;
        reg_wr(v);
        chk("R10 rmw", rd_data, pack(6, 5, 3));

        // R4 wake sets and sticks
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        chk("R4 irq set", {31'b0, irq}, 32'h1);
        repeat (5) @(negedge clk);
        chk("R4 sticky", rd_data, pack(6, 5, 3) | 32'h800);
        chk("R4 irq held", {31'b0, irq}, 32'h1);

        // R5 writing zero to bit 11 keeps the flag, writing one clears it
        reg_wr(pack(6, 5, 3));
        chk("R5 write zero", {31'b0, irq}, 32'h1);
        reg_wr(pack(6, 5, 3) | 32'h800);
        chk("R5 clear", {31'b0, irq}, 32'h0);
        chk("R5 fields kept", rd_data, pack(6, 5, 3));

        // R6 set and clear in the same cycle
        wake_evt = 1'b1;
        reg_wr(pack(6, 5, 3) | 32'h800);
        wake_evt = 1'b0;
        chk("R6 set wins", {31'b0, irq}, 32'h1);
        reg_wr(pack(0, 0, 0) | 32'h800);
        chk("R6 cleared after", {31'b0, irq}, 32'h0);

        // R8 period for each divider value
        for (int dv = 0; dv < 8; dv++) begin
            reg_wr(pack(0, 0, dv));
            repeat (10) @(negedge clk);
            sync_tick();
            for (int k = 0; k < 3; k++) begin
                gap(n);
                chk("R8 period", 32'(n), 32'(dv + 1));
            end
        end

        // R9 divider change mid-stream: old period once more, then new
        reg_wr(pack(0, 0, 7));
        repeat (10) @(negedge clk);
        sync_tick();
        wr_en   = 1'b1;
        wr_data = pack(0, 0, 1);
        @(negedge clk);
        wr_en   = 1'b0;
        n = 1;
        while (!bus_clk_en) begin
            @(negedge clk);
            n++;
        end
        chk("R9 old period kept", 32'(n), 32'd8);
        gap(n);
        chk("R9 new period", 32'(n), 32'd2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule